// File: doc/BRIEF.md
# Dual-Access Configuration Register Bank

This block holds a small bank of configuration words that two masters can reach. The first is a processor-style port with a 16-bit address, separate 16-bit write and read buses, an enable, a write-enable and a one-cycle ready pulse. The second is a management access path with its own address, data, enable and write-enable inputs. It has a matching done pulse. Both paths run on one clock. That clock must run without a break, even when neither path is being used.

A single select input decides which path owns the bank. The path that is not selected is ignored entirely. Each time the select input changes, the bank refuses every access for two clock edges so that the handover can settle. It also refuses an enable that arrives while the previous operation is still finishing. Each refused enable produces a one-cycle error pulse. Addresses beyond the implemented registers are decoded as empty.

Top module: `cfg_dual_port`

## Requirements
- R1: While reset is high, and in the first cycle after it, ready, done, error and both read buses are 0. Every register reads back as 0 after reset.
- R2: With select at 0, an enable at 1 with write-enable at 1 that is accepted stores the write data at the addressed register. Ready is 1 for exactly the one cycle after that clock edge.
- R3: An accepted port read (enable 1, write-enable 0) puts the addressed register on the port read bus in the cycle in which ready is 1. The bus then keeps that value until the next accepted port read.
- R4: A cycle with enable at 0 starts nothing. It produces no ready, no done and no error, and no register changes.
- R5: With select at 1, the management inputs perform reads and writes with the same one-cycle done timing and hold behaviour. In that mode, port enables produce no ready, no error and no register change.
- R6: With select at 0, management enables produce no done, no error and no register change.
- R7: When the select input changes, the enables sampled at the clock edge of the change and at the next edge are refused. An enable at the third edge is accepted.
- R8: An enable on the selected path is refused if it arrives while ready or done is 1, or during the window of R7. A refused enable causes no register change, and error is 1 for the single following cycle.
- R9: Registers occupy addresses 0 to NUM_REGS-1 (16 by default). A write above that range changes nothing but still gives its ready or done pulse. A read above that range returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, shared by both paths |
| rst | input | 1 | Synchronous active-high reset |
| sel_mgmt | input | 1 | 0: port owns the bank, 1: management path owns it |
| port_addr | input | 16 | Port register address |
| port_wdata | input | 16 | Port write data |
| port_en | input | 1 | Port operation enable |
| port_we | input | 1 | Port write-enable (1 write, 0 read) |
| port_rdata | output | 16 | Port read data, held between reads |
| port_ready | output | 1 | Port completion / read-valid pulse |
| mgmt_addr | input | 16 | Management register address |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_en | input | 1 | Management operation enable |
| mgmt_we | input | 1 | Management write-enable (1 write, 0 read) |
| mgmt_rdata | output | 16 | Management read data, held between reads |
| mgmt_done | output | 1 | Management completion / read-valid pulse |
| access_err | output | 1 | Pulse marking a refused enable |

## Verification
The bench targets four risks:

- **Handover window.** It switches the select input while an enable is held high and expects error, then error, then done. A lockout that is one edge short, or that counts from the wrong edge, would let the access through too early.
- **Back-to-back enables.** It holds an enable across two edges. A design that does not track the pending operation would perform a second operation where an error pulse is expected.
- **Unselected path.** It drives writes on the path that is not selected and then reads the same register back on the owning path. Any leak would show up as a corrupted word.
- **Addresses above the bank.** It writes to an address that aliases a live register in its low bits. A truncating decoder would overwrite that register.

Read-bus hold is checked by issuing writes between reads.

// File: rtl/cfg_dual_pkg.sv
package cfg_dual_pkg;

  // Owner of the register bank, taken from the select input.
  typedef enum logic {
    PATH_PORT = 1'b0,
    PATH_MGMT = 1'b1
  } path_e;

endpackage

// File: rtl/cfg_settle_guard.sv
module cfg_settle_guard
  import cfg_dual_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  sel_mgmt,
  output path_e owner,
  output logic  blocked
);

  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;

  logic             sel_q;
  logic [CNT_W-1:0] hold_cnt;
  logic             changed;

  assign changed = (sel_mgmt != sel_q);

  // The edge of the change counts as the first blocked edge.
  // The counter then covers the remaining SETTLE-1 edges.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= sel_mgmt;
      hold_cnt <= '0;
    end else if (changed) begin
      sel_q    <= sel_mgmt;
      hold_cnt <= CNT_W'(SETTLE - 1);
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign blocked = changed || (hold_cnt != '0);
  assign owner   = sel_mgmt ? PATH_MGMT : PATH_PORT;

endmodule

// File: rtl/cfg_path_mux.sv
module cfg_path_mux
  import cfg_dual_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  path_e         owner,
  input  logic [AW-1:0] p_addr,
  input  logic [DW-1:0] p_wdata,
  input  logic          p_en,
  input  logic          p_we,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic          m_en,
  input  logic          m_we,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_wdata,
  output logic          s_en,
  output logic          s_we
);

  always_comb begin
    if (owner == PATH_MGMT) begin
      s_addr  = m_addr;
      s_wdata = m_wdata;
      s_en    = m_en;
      s_we    = m_we;
    end else begin
      s_addr  = p_addr;
      s_wdata = p_wdata;
      s_en    = p_en;
      s_we    = p_we;
    end
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int NUM_REGS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_word
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DW-1:0]    regs [NUM_REGS];
  logic [IDX_W-1:0] idx;
  logic             hit;

  assign idx = addr[IDX_W-1:0];

  // Every address bit above the index field must be zero.
  assign hit = (addr[AW-1:IDX_W] == '0) && (32'(idx) < NUM_REGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_en && hit) begin
      regs[idx] <= wr_data;
    end
  end

  assign rd_word = hit ? regs[idx] : '0;

endmodule

// File: rtl/cfg_dual_port.sv
module cfg_dual_port
  import cfg_dual_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int NUM_REGS = 16,
  parameter int SETTLE   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_mgmt,
  input  logic [AW-1:0] port_addr,
  input  logic [DW-1:0] port_wdata,
  input  logic          port_en,
  input  logic          port_we,
  output logic [DW-1:0] port_rdata,
  output logic          port_ready,
  input  logic [AW-1:0] mgmt_addr,
  input  logic [DW-1:0] mgmt_wdata,
  input  logic          mgmt_en,
  input  logic          mgmt_we,
  output logic [DW-1:0] mgmt_rdata,
  output logic          mgmt_done,
  output logic          access_err
);

  path_e         owner;
  logic          blocked;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  logic          s_en;
  logic          s_we;
  logic [DW-1:0] rd_word;
  logic          busy;
  logic          accept;
  logic          refuse;
  logic          wr_go;
  logic          rd_go;

  cfg_settle_guard #(.SETTLE(SETTLE)) u_guard (
    .clk      (clk),
    .rst      (rst),
    .sel_mgmt (sel_mgmt),
    .owner    (owner),
    .blocked  (blocked)
  );

  cfg_path_mux #(.AW(AW), .DW(DW)) u_mux (
    .owner   (owner),
    .p_addr  (port_addr),
    .p_wdata (port_wdata),
    .p_en    (port_en),
    .p_we    (port_we),
    .m_addr  (mgmt_addr),
    .m_wdata (mgmt_wdata),
    .m_en    (mgmt_en),
    .m_we    (mgmt_we),
    .s_addr  (s_addr),
    .s_wdata (s_wdata),
    .s_en    (s_en),
    .s_we    (s_we)
  );

  // An operation is pending for the one cycle in which its pulse is high.
  assign busy   = port_ready || mgmt_done;
  assign accept = s_en && !blocked && !busy;
  assign refuse = s_en && (blocked || busy);
  assign wr_go  = accept && s_we;
  assign rd_go  = accept && !s_we;

  cfg_reg_bank #(.AW(AW), .DW(DW), .NUM_REGS(NUM_REGS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_go),
    .addr    (s_addr),
    .wr_data (s_wdata),
    .rd_word (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      port_ready <= 1'b0;
      mgmt_done  <= 1'b0;
      access_err <= 1'b0;
      port_rdata <= '0;
      mgmt_rdata <= '0;
    end else begin
      port_ready <= accept && (owner == PATH_PORT);
      mgmt_done  <= accept && (owner == PATH_MGMT);
      access_err <= refuse;
      if (rd_go && owner == PATH_PORT) port_rdata <= rd_word;
      if (rd_go && owner == PATH_MGMT) mgmt_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/cfg_dual_port_chk.sv
module cfg_dual_port_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          sel_mgmt,
  input logic          port_en,
  input logic          mgmt_en,
  input logic          port_ready,
  input logic          mgmt_done,
  input logic          access_err,
  input logic [DW-1:0] port_rdata,
  input logic [DW-1:0] mgmt_rdata
);

  // R2
  ready_single_chk: assert property (@(posedge clk) disable iff (rst)
    port_ready |=> !port_ready);

  // R4
  ready_cause_chk: assert property (@(posedge clk) disable iff (rst)
    port_ready |-> $past(port_en && !sel_mgmt));

  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    mgmt_done |-> $past(mgmt_en && sel_mgmt));

  // R5
  one_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({port_ready, mgmt_done}));

  // R3
  port_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !port_ready |-> $stable(port_rdata));

  // R5
  mgmt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mgmt_done |-> $stable(mgmt_rdata));

  // R7
  lock_first_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_mgmt != $past(sel_mgmt)) |=> !(port_ready || mgmt_done));

  // R7
  lock_second_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sel_mgmt) != $past(sel_mgmt, 2)) |=> !(port_ready || mgmt_done));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    access_err |-> $past(sel_mgmt ? mgmt_en : port_en));

endmodule

bind cfg_dual_port cfg_dual_port_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_mgmt   (sel_mgmt),
  .port_en    (port_en),
  .mgmt_en    (mgmt_en),
  .port_ready (port_ready),
  .mgmt_done  (mgmt_done),
  .access_err (access_err),
  .port_rdata (port_rdata),
  .mgmt_rdata (mgmt_rdata)
);

// File: tb/tb_cfg_dual_port.sv
module tb_cfg_dual_port;

  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 16;
  localparam int SETTLE     = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_mgmt = 1'b0;
  logic [15:0] port_addr = '0, port_wdata = '0;
  logic        port_en = 1'b0, port_we = 1'b0;
  logic [15:0] mgmt_addr = '0, mgmt_wdata = '0;
  logic        mgmt_en = 1'b0, mgmt_we = 1'b0;
  logic [15:0] port_rdata, mgmt_rdata;
  logic        port_ready, mgmt_done, access_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_dual_port dut (
    .clk(clk), .rst(rst), .sel_mgmt(sel_mgmt),
    .port_addr(port_addr), .port_wdata(port_wdata), .port_en(port_en), .port_we(port_we),
    .port_rdata(port_rdata), .port_ready(port_ready),
    .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata), .mgmt_en(mgmt_en), .mgmt_we(mgmt_we),
    .mgmt_rdata(mgmt_rdata), .mgmt_done(mgmt_done), .access_err(access_err)
  );

  // Behavioural reference: cycle counter, time of last select change, plain array.
  int          m_regs [NREG];
  int          cyc, last_chg;
  bit          prev_sel;
  bit          m_ready, m_done, m_err;
  logic [15:0] m_prd, m_mrd;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_regs[i]) m_regs[i] = 0;
      cyc = 0; last_chg = -100; prev_sel = sel_mgmt;
      m_ready = 0; m_done = 0; m_err = 0; m_prd = 0; m_mrd = 0;
    end else begin
      bit pending, locked, en, we;
      int a;
      logic [15:0] d, v;
      cyc++;
      if (sel_mgmt != prev_sel) begin last_chg = cyc; prev_sel = sel_mgmt; end
      locked  = (cyc - last_chg) < SETTLE;
      pending = m_ready || m_done;
      en = sel_mgmt ? mgmt_en : port_en;
      we = sel_mgmt ? mgmt_we : port_we;
      a  = sel_mgmt ? int'(mgmt_addr) : int'(port_addr);
      d  = sel_mgmt ? mgmt_wdata : port_wdata;
      m_ready = 0; m_done = 0; m_err = 0;
      if (en) begin
        if (locked || pending) m_err = 1;
        else begin
          if (we) begin
            if (a < NREG) m_regs[a] = int'(d);
          end else begin
            v = (a < NREG) ? 16'(m_regs[a]) : 16'h0;
            if (sel_mgmt) m_mrd = v; else m_prd = v;
          end
          if (sel_mgmt) m_done = 1; else m_ready = 1;
        end
      end
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Clock-by-clock comparison against the reference.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(16'(port_ready), 16'(m_ready), "R2 model port_ready");
      chk(16'(mgmt_done),  16'(m_done),  "R5 model mgmt_done");
      chk(16'(access_err), 16'(m_err),   "R8 model access_err");
      chk(port_rdata, m_prd, "R3 model port_rdata");
      chk(mgmt_rdata, m_mrd, "R5 model mgmt_rdata");
    end
  end

  task automatic port_op(input bit we, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    port_en = 1; port_we = we; port_addr = a; port_wdata = d;
    @(negedge clk);
    port_en = 0;
  endtask

  task automatic mgmt_op(input bit we, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    mgmt_en = 1; mgmt_we = we; mgmt_addr = a; mgmt_wdata = d;
    @(negedge clk);
    mgmt_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(16'(port_ready), 16'h0, "R1 ready in reset");
    chk(16'(access_err), 16'h0, "R1 err in reset");
    chk(port_rdata, 16'h0, "R1 port_rdata in reset");
    rst = 0;
    @(negedge clk);
    chk(16'(mgmt_done), 16'h0, "R1 done after reset");
    port_op(0, 16'd3, 16'h0);
    chk(port_rdata, 16'h0, "R1 register cleared");

    // R2 writes
    for (int i = 0; i < 6; i++) begin
      port_op(1, 16'(i), 16'hA000 + 16'(i) * 16'h0111);
      chk(16'(port_ready), 16'h1, "R2 write ready");
    end
    @(negedge clk);
    chk(16'(port_ready), 16'h0, "R2 ready single cycle");

    // R3 read and hold
    port_op(0, 16'd2, 16'h0);
    chk(16'(port_ready), 16'h1, "R3 read ready");
    chk(port_rdata, 16'hA222, "R3 read data");
    port_op(1, 16'd7, 16'h55AA);
    @(negedge clk);
    chk(port_rdata, 16'hA222, "R3 hold across write");

    // R4 enable low does nothing
    @(negedge clk);
    port_we = 1; port_addr = 16'd2; port_wdata = 16'h0BAD;
    @(negedge clk);
    chk(16'(port_ready), 16'h0, "R4 no ready");
    chk(16'(access_err), 16'h0, "R4 no error");
    port_op(0, 16'd2, 16'h0);
    chk(port_rdata, 16'hA222, "R4 register unchanged");

    // R9 out-of-range address (100 aliases register 4 in low bits)
    port_op(1, 16'd100, 16'hFFFF);
    chk(16'(port_ready), 16'h1, "R9 ready on range miss");
    port_op(0, 16'd100, 16'h0);
    chk(port_rdata, 16'h0, "R9 miss reads zero");
    port_op(0, 16'd4, 16'h0);
    chk(port_rdata, 16'hA444, "R9 alias untouched");

    // R8 enable while pending
    @(negedge clk);
    port_en = 1; port_we = 0; port_addr = 16'd5;
    @(negedge clk);
    chk(16'(port_ready), 16'h1, "R8 first accepted");
    @(negedge clk);
    port_en = 0;
    chk(16'(access_err), 16'h1, "R8 error on pending");
    chk(16'(port_ready), 16'h0, "R8 no second ready");
    @(negedge clk);
    chk(16'(access_err), 16'h0, "R8 error single cycle");

    // R7 handover window, enable held across it
    @(negedge clk);
    sel_mgmt = 1; mgmt_en = 1; mgmt_we = 0; mgmt_addr = 16'd1;
    @(negedge clk);
    chk(16'(access_err), 16'h1, "R7 refused at change edge");
    chk(16'(mgmt_done), 16'h0, "R7 no done at change edge");
    @(negedge clk);
    chk(16'(access_err), 16'h1, "R7 refused at second edge");
    @(negedge clk);
    mgmt_en = 0;
    chk(16'(mgmt_done), 16'h1, "R7 accepted at third edge");
    chk(mgmt_rdata, 16'hA111, "R7 management read data");

    // R5 management owns bank, port ignored
    port_op(1, 16'd1, 16'hDEAD);
    chk(16'(port_ready), 16'h0, "R5 port ignored no ready");
    chk(16'(access_err), 16'h0, "R5 port ignored no error");
    mgmt_op(0, 16'd1, 16'h0);
    chk(mgmt_rdata, 16'hA111, "R5 register kept");
    mgmt_op(1, 16'd9, 16'h1234);
    chk(16'(mgmt_done), 16'h1, "R5 management write done");
    mgmt_op(0, 16'd9, 16'h0);
    chk(mgmt_rdata, 16'h1234, "R5 management read back");

    // R6 back to port, management ignored
    @(negedge clk);
    sel_mgmt = 0;
    repeat (3) @(negedge clk);
    mgmt_op(1, 16'd0, 16'hBEEF);
    chk(16'(mgmt_done), 16'h0, "R6 no done");
    chk(16'(access_err), 16'h0, "R6 no error");
    port_op(0, 16'd0, 16'h0);
    chk(port_rdata, 16'hA000, "R6 register kept");

    // Mixed traffic against the reference
    for (int n = 0; n < 800; n++) begin
      @(negedge clk);
      port_en    = ($urandom % 3) == 0;
      port_we    = $urandom % 2;
      port_addr  = 16'($urandom % 24);
      port_wdata = 16'($urandom);
      mgmt_en    = ($urandom % 3) == 0;
      mgmt_we    = $urandom % 2;
      mgmt_addr  = 16'($urandom % 24);
      mgmt_wdata = 16'($urandom);
      if (($urandom % 25) == 0) sel_mgmt = ~sel_mgmt;
    end
    @(negedge clk);
    port_en = 0; mgmt_en = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule